// File: doc/BRIEF.md
# Accumulator Processor Control Unit with Interrupt Cycle

A small single-accumulator processor core: a control sequencer plus the registers it steers (program counter, instruction register, accumulator and a pair of shadow registers). It talks to one external synchronous word RAM through a single address port, a write strobe and a write data bus. Read data returns one clock after the address is presented. Each instruction is one 16-bit word. The upper 4 bits are the operation and the lower 12 bits are a memory address.

Every instruction passes through a fetch phase and an execute phase. A closing interrupt-check phase follows. In that phase a level-sensitive request line is sampled. If the request is honoured, the running program's PC and accumulator go into shadow registers, further requests are masked and control moves to a fixed handler address. A dedicated return operation puts both registers back, lifts the mask and lets the interrupted program resume.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low and just after it, PC and accumulator are 0, the interrupt mask and illegal flag are 0 and no write strobe is issued.
- R2: Fetch presents the PC on the address port for one cycle. The returned word becomes the instruction and the PC then advances by one. A load or add takes 5 cycles (fetch, decode, execute, write-back, interrupt check), and every other operation takes 4.
- R3: Operation 0x1 replaces the accumulator with the word at the operand address.
- R4: Operation 0x2 drives the operand address with a write strobe lasting exactly one cycle and write data equal to the accumulator. The accumulator is unchanged.
- R5: Operation 0x5 adds the word at the operand address to the accumulator, modulo 2^16.
- R6: In the interrupt-check cycle, a high request with the mask clear does three things: it copies PC and accumulator to shadow, sets the mask and loads the PC with the handler address (default 0x100). Otherwise the PC is left alone.
- R7: While the mask is set, the request line has no effect on the PC or the shadow registers.
- R8: Operation 0xF restores PC and accumulator from shadow and clears the mask. A request still high in that instruction's check cycle is taken again at once.
- R9: Any other operation leaves the accumulator and memory untouched and sets an illegal flag that stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_rdata | input | 16 | RAM read data, valid one cycle after address |
| mem_addr | output | 12 | RAM word address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 16 | RAM write data |
| pc_q | output | 12 | Program counter |
| ac_q | output | 16 | Accumulator |
| int_mask | output | 1 | Set while the handler runs |
| illegal | output | 1 | Sticky undefined-operation flag |

## Verification
One program mixes loads, a wrapping add, stores and an undefined word, so the phase lengths of 4 and 5 cycles are told apart on every clock. The request line is held high longer than the whole handler. This separates correct masking inside the handler from the immediate re-entry that must follow the return. A later short request then shows a clean single entry. A cycle-level reference model catches any slip in timing, addressing or in which value gets saved or restored.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW  = 12,
  parameter int OPW = 4,
  parameter int DW  = OPW + AW,
  parameter logic [AW-1:0] VEC = 12'h100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] ac_q,
  output logic          int_mask,
  output logic          illegal
);
  localparam logic [OPW-1:0] OP_LD  = OPW'(1);
  localparam logic [OPW-1:0] OP_ST  = OPW'(2);
  localparam logic [OPW-1:0] OP_ADD = OPW'(5);
  localparam logic [OPW-1:0] OP_RET = {OPW{1'b1}};

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_WB, S_INT} phase_t;

  phase_t        st;
  logic [DW-1:0] ir;
  logic [AW-1:0] spc_q;
  logic [DW-1:0] sac_q;

  wire [OPW-1:0] op      = ir[DW-1 -: OPW];
  wire [AW-1:0]  operand = ir[AW-1:0];

  assign mem_addr  = (st == S_EXEC) ? operand : pc_q;
  assign mem_we    = (st == S_EXEC) && (op == OP_ST);
  assign mem_wdata = ac_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_FETCH;
      ir       <= '0;
      pc_q     <= '0;
      ac_q     <= '0;
      spc_q    <= '0;
      sac_q    <= '0;
      int_mask <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      case (st)
        S_FETCH:  st <= S_DECODE;
        S_DECODE: begin
          ir   <= mem_rdata;
          pc_q <= pc_q + 1'b1;
          st   <= S_EXEC;
        end
        S_EXEC: begin
          st <= S_INT;
          case (op)
            OP_LD, OP_ADD: st <= S_WB;
            OP_ST: ;
            OP_RET: begin
              pc_q     <= spc_q;
              ac_q     <= sac_q;
              int_mask <= 1'b0;
            end
            default: illegal <= 1'b1;
          endcase
        end
        S_WB: begin
          ac_q <= (op == OP_LD) ? mem_rdata : ac_q + mem_rdata;
          st   <= S_INT;
        end
        default: begin
          if (irq && !int_mask) begin
            spc_q    <= pc_q;
            sac_q    <= ac_q;
            pc_q     <= VEC;
            int_mask <= 1'b1;
          end
          st <= S_FETCH;
        end
      endcase
    end
  end
endmodule

module acc_cpu_chk #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [AW-1:0] VEC = 12'h100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          mem_we,
  input logic [AW-1:0] pc_q,
  input logic [DW-1:0] ac_q,
  input logic          int_mask,
  input logic          illegal,
  input logic [AW-1:0] spc,
  input logic [DW-1:0] sac
);
  AST_WE_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we);            // R4
  AST_STORE_AC:     assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> $stable(ac_q));      // R4
  AST_VECTOR:       assert property (@(posedge clk) disable iff (!rst_n) $rose(int_mask) |-> pc_q == VEC); // R6
  AST_ENTRY_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(int_mask) |-> $past(irq)); // R6
  AST_MASK_SHADOW:  assert property (@(posedge clk) disable iff (!rst_n)
                      (int_mask && $past(int_mask)) |-> ($stable(spc) && $stable(sac)));                 // R7
  AST_RET_PC:       assert property (@(posedge clk) disable iff (!rst_n) $fell(int_mask) |-> pc_q == $past(spc)); // R8
  AST_RET_AC:       assert property (@(posedge clk) disable iff (!rst_n) $fell(int_mask) |-> ac_q == $past(sac)); // R8
  AST_ILL_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) illegal |=> illegal);           // R9
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .DW(DW), .VEC(VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .mem_we(mem_we), .pc_q(pc_q), .ac_q(ac_q),
  .int_mask(int_mask), .illegal(illegal), .spc(spc_q), .sac(sac_q)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 700;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata;
  logic [11:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [11:0] pc_q;
  logic [15:0] ac_q;
  logic        int_mask;
  logic        illegal;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .pc_q(pc_q), .ac_q(ac_q), .int_mask(int_mask), .illegal(illegal)
  );

  logic [15:0] dmem [4096];
  logic [15:0] mmem [4096];

  always @(posedge clk) begin
    if (mem_we) dmem[mem_addr] <= mem_wdata;
    mem_rdata <= dmem[mem_addr];
  end

  task automatic put(input int a, input logic [15:0] v);
    dmem[a] = v;
    mmem[a] = v;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model state
  int m_st, m_pc, m_ac, m_ir, m_spc, m_sac, m_rd;
  bit m_mask, m_ill;

  function automatic int m_op();
    return (m_ir >> 12) & 15;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pc = 0; m_ac = 0; m_ir = 0; m_spc = 0; m_sac = 0;
      m_mask = 0; m_ill = 0;
    end else begin
      case (m_st)
        0: begin m_rd = mmem[m_pc]; m_st = 1; end
        1: begin m_ir = m_rd; m_pc = (m_pc + 1) % 4096; m_st = 2; end
        2: begin
          m_st = 4;
          if (m_op() == 1 || m_op() == 5) begin m_rd = mmem[m_ir % 4096]; m_st = 3; end
          else if (m_op() == 2) mmem[m_ir % 4096] = m_ac[15:0];
          else if (m_op() == 15) begin m_pc = m_spc; m_ac = m_sac; m_mask = 0; end
          else m_ill = 1;
        end
        3: begin
          m_ac = (m_op() == 1) ? m_rd : (m_ac + m_rd) % 65536;
          m_st = 4;
        end
        default: begin
          if (irq && !m_mask) begin
            m_spc = m_pc; m_sac = m_ac; m_pc = 'h100; m_mask = 1;
          end
          m_st = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int exp_addr = (m_st == 2) ? (m_ir % 4096) : m_pc;
      automatic bit exp_we = (m_st == 2) && (m_op() == 2);
      check(mem_addr == exp_addr[11:0], "R2 addr", mem_addr, exp_addr);
      check(mem_we == exp_we, "R4 we", mem_we, exp_we);
      if (exp_we) check(mem_wdata == m_ac[15:0], "R4 wdata", mem_wdata, m_ac);
      check(pc_q == m_pc[11:0], "R6/R8 pc", pc_q, m_pc);
      check(ac_q == m_ac[15:0], "R3/R5/R8 ac", ac_q, m_ac);
      check(int_mask == m_mask, "R7 mask", int_mask, m_mask);
      check(illegal == m_ill, "R9 illegal", illegal, m_ill);
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) put(i, 16'h0000);
    put(0, 16'h1200); put(1, 16'h5201); put(2, 16'h2202); put(3, 16'h3777);
    put(4, 16'h5201); put(5, 16'h2203);
    for (int i = 6; i < 'h100; i++) put(i, 16'h5204);
    put('h100, 16'h1205); put('h101, 16'h2206); put('h102, 16'hF000);
    put('h200, 16'h1234); put('h201, 16'hF000); put('h204, 16'h0001); put('h205, 16'h0BAD);

    repeat (3) @(negedge clk);
    check(pc_q == 0 && ac_q == 0, "R1 pc/ac", {pc_q, ac_q}, 0);
    check(!int_mask && !illegal && !mem_we, "R1 flags", {int_mask, illegal, mem_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(ac_q == 16'h1234, "R3 load", ac_q, 16'h1234);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(ac_q == 16'h0234, "R5 add wrap", ac_q, 16'h0234);
    check(pc_q == 12'd2, "R2 pc step", pc_q, 2);
    repeat (90) @(negedge clk);
    irq = 1'b1;
    repeat (60) @(negedge clk);
    irq = 1'b0;
    repeat (200) @(negedge clk);
    irq = 1'b1;
    repeat (2) @(negedge clk);
    while (!int_mask) @(negedge clk);
    irq = 1'b0;
    check(pc_q >= 12'h100 && pc_q <= 12'h103, "R6 vector", pc_q, 12'h100);
    repeat (RUN_CYCLES - 360) @(negedge clk);
    check(dmem['h202] == 16'h0234, "R4 store", dmem['h202], 16'h0234);
    check(dmem['h203] == 16'hF234, "R9 no effect", dmem['h203], 16'hF234);
    check(dmem['h206] == 16'h0BAD, "R8 handler", dmem['h206], 16'h0BAD);
    check(illegal == 1'b1, "R9 sticky", illegal, 1);
    check(int_mask == 1'b0, "R8 mask clear", int_mask, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (RUN_CYCLES + 2000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule